// File: doc/BRIEF.md
# Configuration Bitstream Stream Controller

This block sits on a simple 32-bit register bus and streams a configuration bitstream into downstream configurable devices. Software first programs the number of bytes it expects to send while the controller is idle, then sets the enable bit. It can choose one of two feed modes. In processor-fed mode the host itself writes 32-bit words into a data window. In DMA-request mode the block pulses a request line each time half of its FIFO can take a new burst, and a DMA engine answers by writing that burst into the same window.

Words leave the FIFO over a valid/ready port toward the configuration port of the devices. Each consumed word advances a byte counter by four, and the port stops once the programmed total is reached. The block keeps error flags for dropped window writes and for device-reported faults, and a done flag for a completed load. It raises an interrupt on completion or on any error. Clearing the enable bit drops the interrupt, flushes the FIFO and aborts the load. Holding the enable and reset bits together drives a reset line to the devices for as long as both bits stay written.

Register words carry bit 31 as the most significant bit. Reads return data one clock after the read strobe.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: After reset, control (0x40), status (0x44), FIFO-used (0x4C), total (0x50) and current count (0x54) read 0. FIFO-size (0x48) reads FIFO_DEPTH*4. irq, cfg_valid, dma_req and cfg_reset are low.
- R2: A write to the total register (0x50) takes effect only while control bit 0 (enable) is 0. A write to it while enabled leaves the old value.
- R3: While enabled with a non-full FIFO, a write anywhere in 0x3000–0x3FFF pushes the word. Words appear on cfg_data in write order, one per cycle with cfg_valid and cfg_ready both high. FIFO-used reads 4 times the stored word count.
- R4: A window write while disabled or while the FIFO is full is dropped and sets status bit 1 (overflow).
- R5: The current count rises by 4 for each consumed word. cfg_valid stays low once the current count equals the total, even with words left in the FIFO.
- R6: Status bit 18 (done) sets when enabled, current count equals total and cfg_done_in is high. It clears when enable goes from 0 to 1.
- R7: irq rises while enabled when done or any error bit is set. A control write with bit 0 = 0 clears irq, and irq is never high while disabled.
- R8: cfg_err_in high while enabled sets status bit 2 (device error).
- R9: cfg_reset is high from the control write that sets both bit 0 and bit 1 until the next control write that clears either of them.
- R10: With control bit 2 (DMA mode) and enable set, dma_req is a one-cycle pulse. A pulse is issued when the stored words plus words still owed from earlier requests leave room for FIFO_DEPTH/2 more words. Each pulse accounts for FIFO_DEPTH/2 words, and pulses stop once requested bytes reach the total.
- R11: While disabled, the FIFO is flushed and FIFO-used reads 0. An enable rising edge clears the current count and all error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| cfg_data | output | 32 | Word toward the configuration port |
| cfg_valid | output | 1 | cfg_data holds a word to consume |
| cfg_ready | input | 1 | Configuration port accepts the word |
| cfg_done_in | input | 1 | Devices report configuration complete |
| cfg_err_in | input | 1 | Devices report a configuration fault |
| cfg_reset | output | 1 | Reset line to the configured devices |
| dma_req | output | 1 | One-cycle request for a half-FIFO burst |
| irq | output | 1 | Completion or error interrupt |

## Verification
The hardest condition to reach is DMA-mode request pacing. There, a second request can be issued while the first burst is still arriving, and the last request must fall exactly on the byte total. The bench drives this with a responder that answers each counted pulse with a half-FIFO burst while the port drains continuously. It then checks the exact pulse count, the absence of back-to-back pulses, and that the final count lands on the total. The count-limited stop is reached by pushing one word beyond the total and observing that it stays in the FIFO. Random rounds vary port back-pressure against host pushes and check word order.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 14'h0040;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 14'h0044;
  localparam logic [ADDR_W-1:0] OFS_FSIZE = 14'h0048;
  localparam logic [ADDR_W-1:0] OFS_FUSED = 14'h004C;
  localparam logic [ADDR_W-1:0] OFS_TOTAL = 14'h0050;
  localparam logic [ADDR_W-1:0] OFS_CUR   = 14'h0054;
  localparam logic [ADDR_W-1:0] OFS_WIN   = 14'h3000;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_RST = 1;
  localparam int unsigned CTL_DMA = 2;

  localparam int unsigned ST_OVF    = 1;
  localparam int unsigned ST_DEVERR = 2;
  localparam int unsigned ST_DONE   = 18;

  typedef struct packed {
    logic dma;
    logic rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
endmodule

// File: rtl/cfgp_core.sv
module cfgp_core
  import cfgp_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BCNT_W = 32,
  localparam int unsigned CW    = $clog2(DEPTH) + 1,
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              total_we,
  input  logic              win_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CW-1:0]     fifo_cnt,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              cfg_ready,
  input  logic              cfg_done_in,
  input  logic              cfg_err_in,
  output ctrl_t             ctrl_q,
  output logic [BCNT_W-1:0] total_q,
  output logic [BCNT_W-1:0] cur_q,
  output logic              ovf_q,
  output logic              deverr_q,
  output logic              done_q,
  output logic              irq,
  output logic              cfg_reset,
  output logic              push,
  output logic              pop,
  output logic              flush,
  output logic              dma_req,
  output logic              cfg_valid
);
  logic              next_en, start, room_ok;
  logic [CW:0]       owed_q;
  logic [CW+1:0]     room_sum;
  logic [BCNT_W-1:0] reqd_q;

  assign next_en   = ctrl_we ? wdata[CTL_EN] : ctrl_q.en;
  assign start     = ctrl_we & wdata[CTL_EN] & ~ctrl_q.en;
  assign push      = win_we & ctrl_q.en & ~fifo_full;
  assign cfg_valid = ctrl_q.en & ~fifo_empty & (cur_q < total_q);
  assign pop       = cfg_valid & cfg_ready;
  assign flush     = ~ctrl_q.en;
  assign room_sum  = (CW+2)'(fifo_cnt) + (CW+2)'(owed_q) + (CW+2)'(HALF);
  assign room_ok   = (room_sum <= (CW+2)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cfg_reset <= 1'b0;
      total_q   <= '0;
      cur_q     <= '0;
      ovf_q     <= 1'b0;
      deverr_q  <= 1'b0;
      done_q    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_q    <= ctrl_t'(wdata[2:0]);
        cfg_reset <= wdata[CTL_EN] & wdata[CTL_RST];
      end
      if (total_we && !ctrl_q.en) total_q <= wdata[BCNT_W-1:0];

      if (start)    cur_q <= '0;
      else if (pop) cur_q <= cur_q + BCNT_W'(4);

      if (start)                ovf_q <= 1'b0;
      else if (win_we && !push) ovf_q <= 1'b1;

      if (start)                         deverr_q <= 1'b0;
      else if (ctrl_q.en && cfg_err_in) deverr_q <= 1'b1;

      if (start) done_q <= 1'b0;
      else if (ctrl_q.en && cur_q == total_q && cfg_done_in) done_q <= 1'b1;

      if (!next_en || start)              irq <= 1'b0;
      else if (done_q || ovf_q || deverr_q) irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start || !ctrl_q.en) begin
      owed_q  <= '0;
      reqd_q  <= '0;
      dma_req <= 1'b0;
    end else begin
      dma_req <= ctrl_q.dma & ~dma_req & room_ok & (reqd_q < total_q);
      owed_q  <= owed_q + (dma_req ? (CW+1)'(HALF) : '0)
                        - ((push && owed_q != '0) ? (CW+1)'(1) : '0);
      if (dma_req) reqd_q <= reqd_q + BCNT_W'(HALF * 4);
    end
  end

  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst) irq |-> ctrl_q.en);
  p_cur_bound_r5: assert property (@(posedge clk) disable iff (rst) ctrl_q.en |-> cur_q <= total_q);
  p_cur_step_r5: assert property (@(posedge clk) disable iff (rst) pop |=> cur_q == $past(cur_q) + BCNT_W'(4));
  p_done_total_r6: assert property (@(posedge clk) disable iff (rst) $rose(done_q) |-> cur_q == total_q);
  p_dma_room_r10: assert property (@(posedge clk) disable iff (rst) dma_req |-> fifo_cnt <= CW'(DEPTH - HALF));
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfgp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned BCNT_W     = 32,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [13:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [31:0] cfg_data,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  input  logic        cfg_done_in,
  input  logic        cfg_err_in,
  output logic        cfg_reset,
  output logic        dma_req,
  output logic        irq
);
  logic              ctrl_we, total_we, win_we, win_hit;
  logic              push, pop, flush, fifo_full, fifo_empty;
  logic [CW-1:0]     fifo_cnt;
  ctrl_t             ctrl_q;
  logic [BCNT_W-1:0] total_q, cur_q;
  logic              ovf_q, deverr_q, done_q;
  logic [31:0]       stat_word;

  assign win_hit  = (bus_addr >= OFS_WIN);
  assign ctrl_we  = bus_wr && (bus_addr == OFS_CTRL);
  assign total_we = bus_wr && (bus_addr == OFS_TOTAL);
  assign win_we   = bus_wr && win_hit;

  cfgp_core #(.DEPTH(FIFO_DEPTH), .BCNT_W(BCNT_W)) u_core (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .total_we(total_we), .win_we(win_we),
    .wdata(bus_wdata), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .cfg_ready(cfg_ready), .cfg_done_in(cfg_done_in), .cfg_err_in(cfg_err_in),
    .ctrl_q(ctrl_q), .total_q(total_q), .cur_q(cur_q), .ovf_q(ovf_q), .deverr_q(deverr_q),
    .done_q(done_q), .irq(irq), .cfg_reset(cfg_reset), .push(push), .pop(pop),
    .flush(flush), .dma_req(dma_req), .cfg_valid(cfg_valid)
  );

  cfgp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .wdata(bus_wdata), .pop(pop),
    .rdata(cfg_data), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  always_comb begin
    stat_word            = '0;
    stat_word[ST_OVF]    = ovf_q;
    stat_word[ST_DEVERR] = deverr_q;
    stat_word[ST_DONE]   = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata <= 32'(ctrl_q);
        OFS_STAT:  bus_rdata <= stat_word;
        OFS_FSIZE: bus_rdata <= 32'(FIFO_DEPTH * 4);
        OFS_FUSED: bus_rdata <= 32'(fifo_cnt) << 2;
        OFS_TOTAL: bus_rdata <= 32'(total_q);
        OFS_CUR:   bus_rdata <= 32'(cur_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/sim_cfg_stream_ctrl.sv
module sim_cfg_stream_ctrl;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam logic [13:0] A_CTRL = 14'h0040, A_STAT = 14'h0044, A_FSIZE = 14'h0048,
                          A_FUSED = 14'h004C, A_TOTAL = 14'h0050, A_CUR = 14'h0054,
                          A_WIN = 14'h3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cfg_data;
  logic        cfg_valid, cfg_reset, dma_req, irq;
  logic        cfg_ready = 1'b0, cfg_done_in = 1'b0, cfg_err_in = 1'b0;

  cfg_stream_ctrl #(.FIFO_DEPTH(DEPTH), .BCNT_W(32)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_data(cfg_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_done_in(cfg_done_in),
    .cfg_err_in(cfg_err_in), .cfg_reset(cfg_reset), .dma_req(dma_req), .irq(irq)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int pops = 0, req_seen = 0, dup = 0;
  bit rnd_rdy = 0, rdy_val = 0, prev_req = 0;
  logic [31:0] expq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // port side: drive ready, then record the handshake the next edge will see
  always @(negedge clk) begin
    cfg_ready = rnd_rdy ? 1'($urandom_range(0, 1)) : rdy_val;
    #1;
    if (cfg_valid && cfg_ready) begin
      pops++;
      if (expq.size() > 0) chk("R3 word order", cfg_data, expq.pop_front());
      else chk("R5 unexpected word", 32'd1, 32'd0);
    end
  end

  always @(negedge clk) begin
    #1;
    if (dma_req) begin
      req_seen++;
      if (prev_req) dup++;
    end
    prev_req = dma_req;
  end

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic push_word(logic [31:0] d, bit expect_out);
    if (expect_out) expq.push_back(d);
    wr(A_WIN + 14'(($urandom % 1024) * 4), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, pushed, n, served, base_req, guard;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_FSIZE, v); chk("R1 fifo size", v, DEPTH * 4);
    rd(A_FUSED, v); chk("R1 fifo used", v, 0);
    rd(A_TOTAL, v); chk("R1 total", v, 0);
    rd(A_CUR, v);   chk("R1 current", v, 0);
    chk("R1 outputs", {irq, cfg_valid, dma_req, cfg_reset}, 4'b0000);

    // R4 window write while disabled
    push_word(32'hDEAD0001, 0);
    rd(A_STAT, v);  chk("R4 overflow while disabled", v, 32'h2);
    rd(A_FUSED, v); chk("R4 nothing stored", v, 0);
    chk("R7 no irq while disabled", irq, 0);

    // R2 total only while disabled; R11 start clears errors
    wr(A_TOTAL, 32'd64);
    rd(A_TOTAL, v); chk("R2 total written", v, 64);
    wr(A_CTRL, 32'h1);
    wr(A_TOTAL, 32'd8);
    rd(A_TOTAL, v); chk("R2 total held while enabled", v, 64);
    rd(A_STAT, v);  chk("R11 start clears errors", v, 0);

    // R3/R4/R7 fill with port stalled, then overflow
    rdy_val = 0;
    for (int i = 0; i < DEPTH; i++) push_word(32'hA000_0000 + i, 1);
    rd(A_FUSED, v); chk("R3 fifo used full", v, DEPTH * 4);
    push_word(32'hBAD0_0000, 0);
    rd(A_STAT, v);  chk("R4 overflow when full", v, 32'h2);
    chk("R7 irq on error", irq, 1);
    wr(A_CTRL, 32'h0);
    chk("R7 irq cleared by disable", irq, 0);
    rd(A_FUSED, v); chk("R11 flushed when disabled", v, 0);
    expq.delete();

    // R5/R6 count-limited stop and done
    wr(A_TOTAL, 32'd8);
    wr(A_CTRL, 32'h1);
    rdy_val = 1;
    push_word(32'h1111_0001, 1);
    push_word(32'h1111_0002, 1);
    push_word(32'h1111_0003, 0);
    repeat (4) @(negedge clk);
    chk("R5 valid low at total", cfg_valid, 0);
    rd(A_FUSED, v); chk("R5 extra word kept", v, 4);
    rd(A_CUR, v);   chk("R5 current count", v, 8);
    rd(A_STAT, v);  chk("R6 no done without device", v, 0);
    cfg_done_in = 1;
    repeat (3) @(negedge clk);
    rd(A_STAT, v);  chk("R6 done bit", v, 32'h4_0000);
    chk("R7 irq on done", irq, 1);
    cfg_done_in = 0;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v);  chk("R6 done cleared by start", v, 0);
    rd(A_CUR, v);   chk("R11 current cleared by start", v, 0);

    // R8 device error
    @(negedge clk); cfg_err_in = 1;
    @(negedge clk); cfg_err_in = 0;
    repeat (3) @(negedge clk);
    rd(A_STAT, v);  chk("R8 device error bit", v, 32'h4);
    chk("R7 irq on device error", irq, 1);
    wr(A_CTRL, 32'h0);

    // R9 reset pulse
    wr(A_CTRL, 32'h1); chk("R9 no reset with enable only", cfg_reset, 0);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h3); chk("R9 reset asserted", cfg_reset, 1);
    wr(A_CTRL, 32'h0); chk("R9 reset released", cfg_reset, 0);
    expq.delete();

    // R3/R5 random rounds with random back-pressure
    for (int r = 0; r < 2; r++) begin
      n = $urandom_range(20, 60);
      wr(A_CTRL, 32'h0);
      wr(A_TOTAL, 32'(n * 4));
      wr(A_CTRL, 32'h1);
      rnd_rdy = 1;
      base = pops; pushed = 0;
      while (pushed < n) begin
        if ((pushed - (pops - base)) <= DEPTH - 3) begin
          push_word($urandom, 1);
          pushed++;
        end else @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      guard = 0;
      while ((pops - base) < n && guard < 2000) begin @(negedge clk); guard++; end
      chk("R5 all words consumed", 32'(pops - base), 32'(n));
      rd(A_CUR, v);   chk("R5 random current", v, 32'(n * 4));
      rd(A_FUSED, v); chk("R3 drained", v, 0);
      cfg_done_in = 1;
      repeat (3) @(negedge clk);
      rd(A_STAT, v);  chk("R6 random done", v, 32'h4_0000);
      chk("R7 random irq", irq, 1);
      cfg_done_in = 0;
      rnd_rdy = 0;
    end

    // R10 DMA-request mode
    wr(A_CTRL, 32'h0);
    chk("R7 irq cleared", irq, 0);
    wr(A_TOTAL, 32'd96);
    expq.delete();
    rdy_val = 1;
    base_req = req_seen;
    wr(A_CTRL, 32'h5);
    served = 0; guard = 0;
    while (served < 3 && guard < 3000) begin
      @(negedge clk); #2;
      guard++;
      if (req_seen - base_req > served) begin
        for (int k = 0; k < HALF; k++) push_word(32'hC000_0000 + served * 16 + k, 1);
        served++;
      end
    end
    repeat (60) @(negedge clk);
    chk("R10 request count", 32'(req_seen - base_req), 3);
    chk("R10 single-cycle pulses", 32'(dup), 0);
    rd(A_CUR, v);   chk("R10 current at total", v, 96);
    rd(A_FUSED, v); chk("R10 fifo drained", v, 0);
    wr(A_CTRL, 32'h0);

    summary();
    $finish;
  end
endmodule